// File: doc/BRIEF.md
# Fault-Injectable Bit RAM

This block is a single-port memory of 2^ADDR_W one-bit cells. It stands in for a real array while a memory test controller is being brought up. A fault-configuration bundle selects one functional defect: a fault kind, a victim cell, an aggressor cell and a two-bit polarity. Every read and every write then passes through that defect model instead of behaving as ideal storage, so the controller's march sequences can be shown to catch it. Only one fault is active at a time.

A small state machine follows the access stream. It has three states. ST_IDLE means no access was requested in the last cycle. ST_WRITE means the last cycle carried a write. ST_READ means the last cycle carried a read, so the registered read data is valid now. Each state moves to ST_READ on a read request, to ST_WRITE on a write request, and to ST_IDLE when no access is requested. The fault configuration is latched only on idle cycles, so a defect can never change in the middle of an access burst. Latching a new configuration never alters the stored bits. All cells clear to 0 on reset.

Top module: `fram_fault_model`

## Requirements
- R1: After reset every cell reads 0, `rd_data` is 0, `rd_valid` is 0 and the latched fault kind is 0 (none).
- R2: With fault kind 0, a read returns the bit last written to that address. The registered `rd_data` and `rd_valid`=1 appear exactly one cycle after the read request. `rd_valid` is 0 in every other cycle, and `rd_data` holds its value when there is no read.
- R3: With fault kind 1 (stuck-at), a read of the victim returns `flt_pol[0]`, and any write to the victim stores `flt_pol[0]`.
- R4: With fault kind 2 (transition), a write of `flt_pol[0]` to the victim is lost when the victim holds the opposite value. Every other write to the victim succeeds.
- R5: With fault kind 3 (state coupling), the trigger state I is `flt_pol[1]` and the forced value F is `flt_pol[0]`. While the aggressor holds I, a read of the victim returns F and a write to the victim stores F. A write of I to the aggressor also sets the victim to F.
- R6: With fault kind 4 (AND bridge), a read of the victim or of the aggressor returns the AND of the two stored bits.
- R7: With fault kind 5 (OR bridge), a read of the victim or of the aggressor returns the OR of the two stored bits.
- R8: With fault kind 6 (address alias), a write to the victim also writes the aggressor, and a read of either address returns the aggressor's bit.
- R9: The fault inputs are latched only in cycles where `acc_req` is 0. A change presented during an access takes effect after the next idle cycle, and latching a new configuration leaves every stored bit unchanged.
- R10: Under any fault kind, cells other than the victim and the aggressor behave as ideal storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Cell address |
| acc_wdata | input | 1 | Write data bit |
| flt_kind | input | 3 | Fault kind: 0 none, 1 stuck, 2 transition, 3 coupling, 4 AND bridge, 5 OR bridge, 6 alias |
| flt_victim | input | ADDR_W | Victim cell address |
| flt_aggr | input | ADDR_W | Aggressor cell address |
| flt_pol | input | 2 | Bit 0 forced/blocked value, bit 1 coupling trigger state |
| rd_data | output | 1 | Registered read data |
| rd_valid | output | 1 | High the cycle after a read request |

## Verification
Two functions can fall in the same cycle: latching a new fault configuration and carrying out an access under the old one. The bench provokes this by changing the fault inputs while requests are still running. It then checks that those accesses follow the previously latched fault, and that the new fault applies only after an idle cycle. A second collision is a coupling write to the aggressor that also rewrites the victim. It is judged by reading the victim back after the fault has been removed.

// File: rtl/fram_pkg.sv
package fram_pkg;

    typedef enum logic [2:0] {
        FK_NONE   = 3'd0,
        FK_STUCK  = 3'd1,
        FK_TRANS  = 3'd2,
        FK_COUPLE = 3'd3,
        FK_BAND   = 3'd4,
        FK_BOR    = 3'd5,
        FK_ALIAS  = 3'd6
    } fault_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } acc_state_e;

endpackage

// File: rtl/fram_ctrl.sv
module fram_ctrl #(
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_req,
    input  logic                 acc_we,
    input  logic [2:0]           flt_kind,
    input  logic [ADDR_W-1:0]    flt_victim,
    input  logic [ADDR_W-1:0]    flt_aggr,
    input  logic [1:0]           flt_pol,
    output fram_pkg::fault_kind_e cfg_kind,
    output logic [ADDR_W-1:0]    cfg_vic,
    output logic [ADDR_W-1:0]    cfg_agg,
    output logic [1:0]           cfg_pol,
    output logic                 wr_go,
    output logic                 rd_go,
    output logic                 rd_valid
);
    import fram_pkg::*;

    acc_state_e state_q, state_d;
    logic       cfg_load;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_READ: begin
                if (!acc_req)
                    state_d = ST_IDLE;
                else if (acc_we)
                    state_d = ST_WRITE;
                else
                    state_d = ST_READ;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        wr_go    = acc_req && acc_we;
        rd_go    = acc_req && !acc_we;
        cfg_load = !acc_req;
        rd_valid = (state_q == ST_READ);
    end

    // configuration latch, open only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_kind <= FK_NONE;
            cfg_vic  <= '0;
            cfg_agg  <= '0;
            cfg_pol  <= '0;
        end else if (cfg_load) begin
            cfg_kind <= (flt_kind > 3'd6) ? FK_NONE : fault_kind_e'(flt_kind);
            cfg_vic  <= flt_victim;
            cfg_agg  <= flt_aggr;
            cfg_pol  <= flt_pol;
        end
    end

endmodule

// File: rtl/fram_array.sv
module fram_array #(
    parameter int ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_go,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic                     acc_wdata,
    input  fram_pkg::fault_kind_e    cfg_kind,
    input  logic [ADDR_W-1:0]        cfg_vic,
    input  logic [ADDR_W-1:0]        cfg_agg,
    input  logic [1:0]               cfg_pol,
    output logic [(1<<ADDR_W)-1:0]   cells
);
    import fram_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic wr_vic;
    logic alias_wr;
    logic couple_trig;
    logic agg_at_trig;

    always_comb begin
        wr_vic      = wr_go && (acc_addr == cfg_vic);
        alias_wr    = wr_vic && (cfg_kind == FK_ALIAS);
        agg_at_trig = (cells[cfg_agg] == cfg_pol[1]);
        couple_trig = wr_go && (cfg_kind == FK_COUPLE) &&
                      (acc_addr == cfg_agg) && (acc_wdata == cfg_pol[1]);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
        logic nxt;
        logic is_vic;
        logic is_agg;

        always_comb begin
            is_vic = (cfg_vic == IDX);
            is_agg = (cfg_agg == IDX);
            nxt    = cells[i];
            if (wr_go && (acc_addr == IDX)) begin
                nxt = acc_wdata;
                if (is_vic) begin
                    unique case (cfg_kind)
                        FK_STUCK:  nxt = cfg_pol[0];
                        FK_TRANS:  if (acc_wdata == cfg_pol[0] &&
                                       cells[i] != cfg_pol[0])
                                       nxt = cells[i];
                        FK_COUPLE: if (agg_at_trig && !is_agg)
                                       nxt = cfg_pol[0];
                        default:   nxt = acc_wdata;
                    endcase
                end
            end
            if (alias_wr && is_agg)
                nxt = acc_wdata;
            if (couple_trig && is_vic && !is_agg)
                nxt = cfg_pol[0];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[i] <= 1'b0;
            else
                cells[i] <= nxt;
        end
    end

endmodule

// File: rtl/fram_readpath.sv
module fram_readpath #(
    parameter int ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_go,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [(1<<ADDR_W)-1:0]   cells,
    input  fram_pkg::fault_kind_e    cfg_kind,
    input  logic [ADDR_W-1:0]        cfg_vic,
    input  logic [ADDR_W-1:0]        cfg_agg,
    input  logic [1:0]               cfg_pol,
    output logic                     rd_data
);
    import fram_pkg::*;

    logic eff;
    logic hit_vic;
    logic hit_pair;
    logic bit_vic;
    logic bit_agg;

    always_comb begin
        hit_vic  = (acc_addr == cfg_vic);
        hit_pair = hit_vic || (acc_addr == cfg_agg);
        bit_vic  = cells[cfg_vic];
        bit_agg  = cells[cfg_agg];
        eff      = cells[acc_addr];
        unique case (cfg_kind)
            FK_STUCK:  if (hit_vic) eff = cfg_pol[0];
            FK_COUPLE: if (hit_vic && bit_agg == cfg_pol[1]) eff = cfg_pol[0];
            FK_BAND:   if (hit_pair) eff = bit_vic & bit_agg;
            FK_BOR:    if (hit_pair) eff = bit_vic | bit_agg;
            FK_ALIAS:  if (hit_pair) eff = bit_agg;
            default:   eff = cells[acc_addr];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= 1'b0;
        else if (rd_go)
            rd_data <= eff;
    end

endmodule

// File: rtl/fram_fault_model.sv
module fram_fault_model #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wdata,
    input  logic [2:0]        flt_kind,
    input  logic [ADDR_W-1:0] flt_victim,
    input  logic [ADDR_W-1:0] flt_aggr,
    input  logic [1:0]        flt_pol,
    output logic              rd_data,
    output logic              rd_valid
);
    import fram_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    fault_kind_e       cfg_kind;
    logic [ADDR_W-1:0] cfg_vic;
    logic [ADDR_W-1:0] cfg_agg;
    logic [1:0]        cfg_pol;
    logic              wr_go;
    logic              rd_go;
    logic [DEPTH-1:0]  cells;

    fram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_req    (acc_req),
        .acc_we     (acc_we),
        .flt_kind   (flt_kind),
        .flt_victim (flt_victim),
        .flt_aggr   (flt_aggr),
        .flt_pol    (flt_pol),
        .cfg_kind   (cfg_kind),
        .cfg_vic    (cfg_vic),
        .cfg_agg    (cfg_agg),
        .cfg_pol    (cfg_pol),
        .wr_go      (wr_go),
        .rd_go      (rd_go),
        .rd_valid   (rd_valid)
    );

    fram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .cfg_kind  (cfg_kind),
        .cfg_vic   (cfg_vic),
        .cfg_agg   (cfg_agg),
        .cfg_pol   (cfg_pol),
        .cells     (cells)
    );

    fram_readpath #(.ADDR_W(ADDR_W)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (rd_go),
        .acc_addr (acc_addr),
        .cells    (cells),
        .cfg_kind (cfg_kind),
        .cfg_vic  (cfg_vic),
        .cfg_agg  (cfg_agg),
        .cfg_pol  (cfg_pol),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/fram_fault_chk.sv
module fram_fault_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_req,
    input logic              acc_we,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [2:0]        flt_kind,
    input logic [2:0]        cfg_kind,
    input logic [ADDR_W-1:0] cfg_vic,
    input logic [1:0]        cfg_pol,
    input logic              rd_data,
    input logic              rd_valid
);

    assert_valid_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_we) |=> rd_valid);

    assert_no_valid_otherwise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_req && !acc_we) |=> !rd_valid);

    assert_data_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_req && !acc_we) |=> $stable(rd_data));

    assert_stuck_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_we && cfg_kind == 3'd1 && acc_addr == cfg_vic)
        |=> (rd_data == $past(cfg_pol[0])));

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> $stable(cfg_kind) && $stable(cfg_vic) && $stable(cfg_pol));

    assert_cfg_loaded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_req && flt_kind <= 3'd6) |=> (cfg_kind == $past(flt_kind)));

endmodule

bind fram_fault_model fram_fault_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_req  (acc_req),
    .acc_we   (acc_we),
    .acc_addr (acc_addr),
    .flt_kind (flt_kind),
    .cfg_kind (cfg_kind),
    .cfg_vic  (cfg_vic),
    .cfg_pol  (cfg_pol),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/sim_fram_fault_model.sv
module sim_fram_fault_model;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_req = 1'b0;
    logic          acc_we = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_wdata = 1'b0;
    logic [2:0]    flt_kind = '0;
    logic [AW-1:0] flt_victim = '0;
    logic [AW-1:0] flt_aggr = '0;
    logic [1:0]    flt_pol = '0;
    logic          rd_data;
    logic          rd_valid;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // bench reference state
    bit [DEPTH-1:0] mm;
    int             mk;
    int             mv;
    int             ma;
    bit [1:0]       mp;

    always #10 clk = ~clk;

    fram_fault_model #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .flt_kind(flt_kind),
        .flt_victim(flt_victim), .flt_aggr(flt_aggr), .flt_pol(flt_pol),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic bit m_read(int ad);
        bit r = mm[ad];
        bit pair = (ad == mv) || (ad == ma);
        case (mk)
            1: if (ad == mv) r = mp[0];
            3: if (ad == mv && mm[ma] == mp[1]) r = mp[0];
            4: if (pair) r = mm[mv] & mm[ma];
            5: if (pair) r = mm[mv] | mm[ma];
            6: if (pair) r = mm[ma];
            default: r = mm[ad];
        endcase
        return r;
    endfunction

    function automatic void m_write(int ad, bit d);
        bit [DEPTH-1:0] old = mm;
        mm[ad] = d;
        if (ad == mv) begin
            case (mk)
                1: mm[mv] = mp[0];
                2: if (d == mp[0] && old[mv] != mp[0]) mm[mv] = old[mv];
                3: if (old[ma] == mp[1]) mm[mv] = mp[0];
                6: mm[ma] = d;
                default: ;
            endcase
        end
        if (mk == 3 && ad == ma && d == mp[1]) mm[mv] = mp[0];
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_idle();
        acc_req = 1'b0;
        @(negedge clk);
        mk = flt_kind; mv = flt_victim; ma = flt_aggr; mp = flt_pol;
    endtask

    task automatic t_write(int ad, bit d, string req);
        acc_req = 1'b1; acc_we = 1'b1; acc_addr = AW'(ad); acc_wdata = d;
        @(negedge clk);
        m_write(ad, d);
        check({req, " no valid after write"}, rd_valid, 0);
    endtask

    task automatic t_read(int ad, string req);
        bit e = m_read(ad);
        acc_req = 1'b1; acc_we = 1'b0; acc_addr = AW'(ad);
        @(negedge clk);
        check({req, " rd_data"}, rd_data, e);
        check({req, " rd_valid"}, rd_valid, 1);
    endtask

    task automatic set_cfg(int k, int v, int a, bit [1:0] p);
        flt_kind = 3'(k); flt_victim = AW'(v); flt_aggr = AW'(a); flt_pol = p;
        t_idle();
    endtask

    task automatic sweep(string req);
        for (int i = 0; i < DEPTH; i++) t_read(i, req);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        mm = '0; mk = 0; mv = 0; ma = 0; mp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rd_valid", rd_valid, 0);
        check("R1 rd_data", rd_data, 0);
        t_idle();
        check("R1 idle rd_valid", rd_valid, 0);
        sweep("R1");

        // R2: ideal behaviour
        t_write(5, 1, "R2"); t_write(6, 0, "R2"); t_write(7, 1, "R2");
        t_read(5, "R2"); t_read(6, "R2"); t_read(7, "R2");
        t_idle();
        check("R2 idle no valid", rd_valid, 0);
        check("R2 data held", rd_data, 1);

        // R3: stuck-at 1 on cell 10, neighbour 11 untouched (R10)
        set_cfg(1, 10, 11, 2'b01);
        t_write(10, 0, "R3"); t_read(10, "R3");
        check("R3 stuck reads 1", rd_data, 1);
        t_write(11, 0, "R10"); t_read(11, "R10");
        check("R10 neighbour ideal", rd_data, 0);

        // R4: transition, cannot rise (pol0=1)
        set_cfg(2, 20, 21, 2'b01);
        t_write(20, 1, "R4"); t_read(20, "R4");
        check("R4 rise blocked", rd_data, 0);
        set_cfg(0, 0, 0, 2'b00);
        t_write(22, 1, "R4");
        set_cfg(2, 22, 21, 2'b00);
        t_write(22, 0, "R4"); t_read(22, "R4");
        check("R4 fall blocked", rd_data, 1);

        // R5: coupling <1;0> aggressor 31 victim 30
        set_cfg(0, 0, 0, 2'b00);
        t_write(30, 1, "R5");
        set_cfg(3, 30, 31, 2'b10);
        t_read(30, "R5");
        check("R5 aggressor idle victim keeps 1", rd_data, 1);
        t_write(31, 1, "R5"); t_read(30, "R5");
        check("R5 victim forced", rd_data, 0);
        t_write(31, 0, "R5"); t_read(30, "R5");
        check("R5 victim stored value", rd_data, 0);

        // R6 / R7 bridges
        set_cfg(0, 0, 0, 2'b00);
        t_write(40, 1, "R6"); t_write(41, 0, "R6");
        set_cfg(4, 40, 41, 2'b00);
        t_read(40, "R6"); check("R6 AND victim", rd_data, 0);
        t_read(41, "R6");
        set_cfg(5, 40, 41, 2'b00);
        t_read(41, "R7"); check("R7 OR aggressor", rd_data, 1);
        t_read(40, "R7");

        // R8 alias
        set_cfg(6, 50, 51, 2'b00);
        t_write(50, 1, "R8"); t_read(51, "R8");
        check("R8 alias write reaches aggressor", rd_data, 1);
        t_write(51, 0, "R8"); t_read(50, "R8");
        check("R8 victim reads aggressor", rd_data, 0);

        // R9: config presented during accesses is not latched
        set_cfg(1, 12, 13, 2'b01);
        flt_kind = 3'd0;
        acc_req = 1'b1;
        t_read(12, "R9");
        check("R9 old stuck still active", rd_data, 1);
        t_write(12, 0, "R9");
        t_idle();
        t_read(12, "R9");
        check("R9 new config after idle", rd_data, 1);
        sweep("R9");

        // random phase across all kinds
        for (int k = 0; k <= 6; k++) begin
            int v = $urandom_range(DEPTH - 1);
            int a = (v + 1 + $urandom_range(DEPTH - 2)) % DEPTH;
            set_cfg(k, v, a, 2'($urandom_range(3)));
            for (int n = 0; n < 120; n++) begin
                int sel = $urandom_range(3);
                int ad = (sel == 0) ? v : (sel == 1) ? a : $urandom_range(DEPTH - 1);
                if ($urandom_range(1) == 1) t_write(ad, 1'($urandom_range(1)), "R10 random");
                else t_read(ad, "R10 random");
                if ($urandom_range(15) == 0) t_idle();
            end
            set_cfg(0, 0, 0, 2'b00);
            sweep("R9 contents kept");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule